// File: doc/BRIEF.md
# Sleep-Mode Edge Recorder

This block sits between a bank of external interrupt lines and a parent interrupt controller that may lose power during sleep. While the parent is awake, the block passes every line straight through. Before the parent is powered down, software enables the block in edge-only capture mode. From then on the outputs stay quiet, and every qualifying edge on an unmasked, edge-sensitive line is latched into a per-line status bit. After wake-up, software issues a flush command. The block then replays each recorded edge as a single one-clock pulse toward the parent and clears the matching status bits.

Edges are recorded at all times, even when the block is disabled. Software therefore acknowledges stale status bits before it arms the block. Each line has three configuration bits: mask, sense and polarity. Each is reached through a write-one-to-set and a write-one-to-clear register group on a simple word-addressed bus. Line n sits in word n/32 of a group, at bit n%32. The design supports up to 512 lines.

Top module: `sleep_edge_recorder`

## Requirements
- R1: After a synchronous reset, the following all read 0: mask, sense, polarity, status, enable and edge-only. All outputs are also 0.
- R2: For each of mask, sense and polarity, a write to the set group (0xC0, 0x180, 0x240) sets every bit written as 1. A write to the clear group (0x100, 0x1C0, 0x280) clears every bit written as 1. Bits written as 0 are left unchanged. Both the set and the clear address of a group read back the current bits. Line n is at word offset 4*(n/32) from the group base, at bit n%32.
- R3: A line with polarity 1 records a rising edge, and a line with polarity 0 records a falling edge. The status bit is visible on the next read once the edge has passed the two-flop synchronizer.
- R4: Edges are recorded whatever the values of enable and edge-only.
- R5: A line whose mask bit is 1, or whose sense bit is 1 (level sensitive), never sets its status bit.
- R6: Writing 1 to a bit of the acknowledge group (0x40) clears that status bit, and 0 bits leave status untouched. Reading the acknowledge group returns the raw status bits.
- R7: A control write with bit 2 (flush) set drives a one-clock pulse on the output of every line whose status is 1 and whose mask is 0. The pulse appears in the clock after the write. Those status bits are cleared. Masked lines keep their status and give no pulse.
- R8: The control word (0x300) holds enable in bit 0 and edge-only in bit 1. The flush bit is not stored and always reads 0.
- R9: Unless enable and edge-only are both 1, each output follows its input three clocks late (two synchronizer flops plus the output register), ORed with any flush pulse.
- R10: When enable and edge-only are both 1, the outputs are 0 except for flush pulses.
- R11: If an edge is recorded in the same clock that an acknowledge or a flush clears the same status bit, the status bit ends up set. A flush still emits its pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Asynchronous external interrupt lines |
| irq_out | output | N_LINES | Registered lines toward the parent controller |
| bus_we | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one clock after bus_rd |

## Verification
Two functions can land on the same status bit in one clock: recording a newly detected edge, and clearing that bit through an acknowledge or a flush. The bench first records an edge on one line and lets the line fall back. It then raises the line again and times the acknowledge write, and later the flush write, so that the bus write is sampled on exactly the clock at which the synchronized edge sets status. The outcome is judged by reading the status back, which must still show the bit, and, for the flush, by sampling the output in the following clock, which must carry the replay pulse.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WORD_W = 32;

  // group code = address bits [11:6]; word index = address bits [5:2]
  localparam logic [5:0] GRP_ACK  = 6'h01;
  localparam logic [5:0] GRP_MSET = 6'h03;
  localparam logic [5:0] GRP_MCLR = 6'h04;
  localparam logic [5:0] GRP_SSET = 6'h06;
  localparam logic [5:0] GRP_SCLR = 6'h07;
  localparam logic [5:0] GRP_PSET = 6'h09;
  localparam logic [5:0] GRP_PCLR = 6'h0A;
  localparam logic [5:0] GRP_CTRL = 6'h0C;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 12'h300;

  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_EDGE  = 1;
  localparam int unsigned CB_FLUSH = 2;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [1:0] sh;
    logic       prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= 2'b00;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[0], raw_in[i]};
        prev <= sh[1];
      end
    end
    assign lvl[i]  = sh[1];
    assign rise[i] = sh[1] & ~prev;
    assign fall[i] = ~sh[1] & prev;
  end
endmodule

// File: rtl/ser_regs.sv
module ser_regs
  import ser_pkg::*;
#(
  parameter int unsigned N = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [N-1:0]      status,
  output logic [N-1:0]      mask,
  output logic [N-1:0]      sense,
  output logic [N-1:0]      pol,
  output logic              en,
  output logic              edge_only,
  output logic [N-1:0]      ack_clr,
  output logic              flush_req,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned NUM_WORDS = (N + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD       = NUM_WORDS * WORD_W;

  logic [5:0]        grp;
  logic [3:0]        widx;
  logic              aligned;
  logic              wr_ok;
  logic [PAD-1:0]    wr_bits;
  logic [N-1:0]      wv;
  logic [PAD-1:0]    src;
  logic [WORD_W-1:0] word;

  assign grp     = addr[11:6];
  assign widx    = addr[5:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wr_ok   = wr_en && aligned;

  always_comb begin
    wr_bits = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (widx == 4'(w)) wr_bits[w*WORD_W +: WORD_W] = wdata;
    end
  end
  assign wv = wr_bits[N-1:0];

  assign ack_clr   = (wr_ok && grp == GRP_ACK) ? wv : '0;
  assign flush_req = wr_ok && grp == GRP_CTRL && widx == 4'd0 && wdata[CB_FLUSH];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask      <= '0;
      sense     <= '0;
      pol       <= '0;
      en        <= 1'b0;
      edge_only <= 1'b0;
    end else if (wr_ok) begin
      case (grp)
        GRP_MSET: mask  <= mask | wv;
        GRP_MCLR: mask  <= mask & ~wv;
        GRP_SSET: sense <= sense | wv;
        GRP_SCLR: sense <= sense & ~wv;
        GRP_PSET: pol   <= pol | wv;
        GRP_PCLR: pol   <= pol & ~wv;
        GRP_CTRL: begin
          if (widx == 4'd0) begin
            en        <= wdata[CB_EN];
            edge_only <= wdata[CB_EDGE];
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    src = '0;
    case (grp)
      GRP_ACK:            src[N-1:0] = status;
      GRP_MSET, GRP_MCLR: src[N-1:0] = mask;
      GRP_SSET, GRP_SCLR: src[N-1:0] = sense;
      GRP_PSET, GRP_PCLR: src[N-1:0] = pol;
      default:            src        = '0;
    endcase
    word = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (widx == 4'(w)) word = src[w*WORD_W +: WORD_W];
    end
    if (grp == GRP_CTRL && widx == 4'd0) begin
      word = '0;
      word[CB_EN]   = en;
      word[CB_EDGE] = edge_only;
    end
    if (!aligned) word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? word : '0;
  end
endmodule

// File: rtl/ser_capture.sv
module ser_capture #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] fall,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] sense,
  input  logic [N-1:0] pol,
  input  logic         en,
  input  logic         edge_only,
  input  logic [N-1:0] ack_clr,
  input  logic         flush_req,
  output logic [N-1:0] status,
  output logic [N-1:0] out_q
);
  logic [N-1:0] hit;
  logic [N-1:0] set_ev;
  logic [N-1:0] flush_vec;
  logic [N-1:0] clr;
  logic         hold;

  assign hit       = (pol & rise) | (~pol & fall);
  assign set_ev    = hit & ~mask & ~sense;
  assign flush_vec = flush_req ? (status & ~mask) : '0;
  assign clr       = ack_clr | flush_vec;
  assign hold      = en & edge_only;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      out_q  <= '0;
    end else begin
      status <= (status & ~clr) | set_ev;
      out_q  <= flush_vec | (hold ? '0 : lvl);
    end
  end
endmodule

// File: rtl/sleep_edge_recorder.sv
module sleep_edge_recorder
  import ser_pkg::*;
#(
  parameter int unsigned N_LINES = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  output logic [N_LINES-1:0] irq_out,
  input  logic               bus_we,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata
);
  logic [N_LINES-1:0] lvl_w, rise_w, fall_w;
  logic [N_LINES-1:0] mask_w, sense_w, pol_w, ack_w, status_w;
  logic               en_w, edge_w, flush_w;

  ser_sync #(.N(N_LINES)) u_sync (
    .clk(clk), .rst(rst), .raw_in(irq_in),
    .lvl(lvl_w), .rise(rise_w), .fall(fall_w)
  );

  ser_regs #(.N(N_LINES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_we), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .status(status_w),
    .mask(mask_w), .sense(sense_w), .pol(pol_w),
    .en(en_w), .edge_only(edge_w), .ack_clr(ack_w),
    .flush_req(flush_w), .rdata(bus_rdata)
  );

  ser_capture #(.N(N_LINES)) u_cap (
    .clk(clk), .rst(rst), .lvl(lvl_w), .rise(rise_w), .fall(fall_w),
    .mask(mask_w), .sense(sense_w), .pol(pol_w),
    .en(en_w), .edge_only(edge_w), .ack_clr(ack_w),
    .flush_req(flush_w), .status(status_w), .out_q(irq_out)
  );
endmodule

// File: rtl/ser_checker.sv
module ser_checker
  import ser_pkg::*;
#(
  parameter int unsigned N = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      irq_out,
  input logic [N-1:0]      status,
  input logic [N-1:0]      mask,
  input logic [N-1:0]      sense,
  input logic [N-1:0]      lvl,
  input logic              en,
  input logic              edge_only,
  input logic              flush_req,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rd_flush_bit
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && status == '0));

  assert_masked_no_record_R5: assert property (@(posedge clk) disable iff (rst)
    ((status & ~$past(status) & ($past(mask) | $past(sense))) == '0));

  assert_flush_replay_R7: assert property (@(posedge clk) disable iff (rst)
    (flush_req && en && edge_only) |=> (irq_out == $past(status & ~mask)));

  assert_flush_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == CTRL_ADDR) |=> (rd_flush_bit == 1'b0));

  assert_bypass_follow_R9: assert property (@(posedge clk) disable iff (rst)
    (!(en && edge_only) && !flush_req) |=> (irq_out == $past(lvl)));

  assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (en && edge_only && !flush_req) |=> (irq_out == '0));
endmodule

bind sleep_edge_recorder ser_checker #(.N(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .irq_out(irq_out), .status(status_w),
  .mask(mask_w), .sense(sense_w), .lvl(lvl_w), .en(en_w),
  .edge_only(edge_w), .flush_req(flush_w), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .rd_flush_bit(bus_rdata[2])
);

// File: tb/sleep_edge_recorder_tb.sv
`timescale 1ns/1ps
module sleep_edge_recorder_tb;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic [N-1:0]  irq_out;
  logic          bus_we = 1'b0, bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;

  int compared = 0, mismatched = 0;
  logic [N-1:0] m = '0, s = '0, p = '0, exp_st = '0, cur_in = '0;
  logic ctl_en = 1'b0, ctl_edge = 1'b0;

  always #10 clk = ~clk;

  sleep_edge_recorder #(.N_LINES(N)) u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .irq_out(irq_out),
    .bus_we(bus_we), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic write64(input logic [11:0] base, input logic [N-1:0] v);
    bus_write(base, v[31:0]);
    bus_write(base + 12'd4, v[63:32]);
  endtask

  task automatic read64(input logic [11:0] base, output logic [N-1:0] v);
    logic [31:0] lo, hi;
    bus_read(base, lo);
    bus_read(base + 12'd4, hi);
    v = {hi, lo};
  endtask

  function automatic logic [31:0] ctl_word(input logic f);
    return {29'd0, f, ctl_edge, ctl_en};
  endfunction

  function automatic logic [N-1:0] qualify(input logic [N-1:0] nv, input logic [N-1:0] ov);
    logic [N-1:0] r, f;
    r = nv & ~ov;
    f = ~nv & ov;
    return ((p & r) | (~p & f)) & ~m & ~s;
  endfunction

  task automatic drive_lines(input logic [N-1:0] v);
    @(negedge clk);
    exp_st = exp_st | qualify(v, cur_in);
    irq_in = v;
    cur_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [N-1:0] nm, input logic [N-1:0] ns, input logic [N-1:0] np);
    write64(12'h100, '1); write64(12'h0C0, nm);
    write64(12'h1C0, '1); write64(12'h180, ns);
    write64(12'h280, '1); write64(12'h240, np);
    m = nm; s = ns; p = np;
  endtask

  task automatic do_flush(input string req);
    logic [N-1:0] pulse, after, hold_mask;
    hold_mask = (ctl_en && ctl_edge) ? '0 : cur_in;
    @(negedge clk); bus_we = 1'b1; bus_addr = 12'h300; bus_wdata = ctl_word(1'b1);
    @(negedge clk); bus_we = 1'b0; pulse = irq_out;
    @(negedge clk); after = irq_out;
    check({req, " flush pulse"}, pulse, (exp_st & ~m) | hold_mask);
    check({req, " pulse one clock"}, after, hold_mask);
    exp_st = exp_st & m;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    logic [31:0]  w;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 out", irq_out, '0);
    read64(12'h0C0, v); check("R1 mask", v, '0);
    read64(12'h180, v); check("R1 sense", v, '0);
    read64(12'h240, v); check("R1 pol", v, '0);
    read64(12'h040, v); check("R1 status", v, '0);
    bus_read(12'h300, w); check("R1 ctrl", 64'(w), '0);

    // R2 write-one-to-set / clear, word and bit placement
    bus_write(12'h0C0, 32'h0000_00F0);
    bus_write(12'h0C4, 32'h8000_0001);
    bus_write(12'h100, 32'h0000_0030);
    read64(12'h0C0, v); check("R2 mask via set", v, 64'h8000_0001_0000_00C0);
    read64(12'h100, v); check("R2 mask via clear", v, 64'h8000_0001_0000_00C0);
    bus_write(12'h184, 32'h0000_0100);
    bus_write(12'h244, 32'h0000_0100);
    bus_write(12'h284, 32'h0000_0000);
    read64(12'h1C0, v); check("R2 sense line 40", v, 64'h0000_0100_0000_0000);
    read64(12'h280, v); check("R2 pol line 40", v, 64'h0000_0100_0000_0000);
    set_cfg('0, '0, '0);

    // R8 control readback, flush not stored
    bus_write(12'h300, 32'h7);
    bus_read(12'h300, w); check("R8 ctrl read", 64'(w), 64'h3);
    bus_write(12'h300, 32'h0);

    // R9 bypass with enable clear
    ctl_en = 1'b0; ctl_edge = 1'b0;
    for (int k = 0; k < 6; k++) begin
      drive_lines({$urandom, $urandom});
      check("R9 bypass follows", irq_out, cur_in);
    end
    exp_st = '0;
    write64(12'h040, '1);

    // random phases: R3 R4 R5 R9 R10 R7
    for (int ph = 0; ph < 3; ph++) begin
      ctl_en   = (ph != 0);
      ctl_edge = (ph == 2);
      bus_write(12'h300, ctl_word(1'b0));
      set_cfg({$urandom, $urandom} & {$urandom, $urandom},
              {$urandom, $urandom} & {$urandom, $urandom},
              {$urandom, $urandom});
      for (int k = 0; k < 20; k++) begin
        drive_lines({$urandom, $urandom});
        if (ctl_en && ctl_edge) check("R10 outputs held low", irq_out, '0);
        else                    check("R9 bypass follows", irq_out, cur_in);
      end
      read64(12'h040, v); check("R3 R4 R5 recorded status", v, exp_st);
      do_flush("R7");
      read64(12'h040, v); check("R7 status after flush", v, exp_st);
      write64(12'h040, '1); exp_st = '0;
    end

    // R3 directed polarity, line 3 rising, line 35 falling
    ctl_en = 1'b1; ctl_edge = 1'b1;
    bus_write(12'h300, ctl_word(1'b0));
    set_cfg('0, '0, 64'h0000_0000_0000_0008);
    drive_lines('0);
    write64(12'h040, '1); exp_st = '0;
    drive_lines(64'h0000_0008_0000_0008);
    drive_lines(64'h0000_0000_0000_0000);
    read64(12'h040, v); check("R3 polarity select", v, 64'h0000_0008_0000_0008);

    // R6 acknowledge clears only written ones
    bus_write(12'h044, 32'h0000_0000);
    read64(12'h040, v); check("R6 zero ack no effect", v, 64'h0000_0008_0000_0008);
    bus_write(12'h044, 32'h0000_0008);
    read64(12'h040, v); check("R6 ack clears bit", v, 64'h0000_0000_0000_0008);
    exp_st = 64'h8;
    do_flush("R7 directed");

    // R11 edge coincides with acknowledge
    set_cfg('0, '0, 64'h20);
    drive_lines(64'h20);
    drive_lines(64'h0);
    @(negedge clk); irq_in = 64'h20; cur_in = 64'h20;
    @(negedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 12'h040; bus_wdata = 32'h20;
    @(negedge clk); bus_we = 1'b0;
    read64(12'h040, v); check("R11 edge beats ack", v, 64'h20);

    // R11 edge coincides with flush
    drive_lines(64'h0);
    @(negedge clk); irq_in = 64'h20; cur_in = 64'h20;
    @(negedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 12'h300; bus_wdata = ctl_word(1'b1);
    @(negedge clk); bus_we = 1'b0;
    check("R11 flush pulse", irq_out, 64'h20);
    read64(12'h040, v); check("R11 edge beats flush", v, 64'h20);

    // R5 masked status kept across flush
    bus_write(12'h0C0, 32'h20);
    m = 64'h20; exp_st = 64'h20;
    do_flush("R5 R7 masked");
    read64(12'h040, v); check("R7 masked status kept", v, 64'h20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule